// File: doc/BRIEF.md
# Adaptive coarse/fine switch-array controller for a digital low-dropout regulator

The block is the digital feedback loop of a digital low-dropout regulator. On every control clock it samples a one-bit comparator decision. A decision of 1 means the regulated output is below its reference. The controller answers by enabling one more power switch or disabling one. The switch count sits in a clamped up/down register. That register drives a thermometer-coded enable bus for an array of N PMOS switches.

A run detector watches the decision stream. After K identical decisions in a row it puts the loop into coarse mode. In coarse mode each control cycle moves the count by two, which stands in for the doubled shift edge of the clock conversion stage. The first decision that differs returns the loop to fine mode with a single-switch step.

The count holds at 0 and at N, so it never wraps. The block also reports the current mode and whether the count is pinned at either end. Everything runs in one clock domain with a synchronous, active-low reset.

Top module: `dldo_ctrl`

## Requirements
- R1: While rst_n is low at a rising clock edge, the enabled-switch count becomes N/2 and coarse becomes 0. With the defaults the count is 8 and sw_en is 16'h00FF.
- R2: sw_en is thermometer coded. With a count of c, bits [c-1:0] are 1 and all other bits are 0.
- R3: In fine operation the count moves by exactly one step per edge. A sampled decision of 1 adds one switch and a decision of 0 removes one. Fine operation applies when coarse was 0 before the edge, or when the decision differs from the previous one.
- R4: coarse becomes 1 after the edge that samples the K-th consecutive identical decision (K = 3 by default). It stays 1 as long as the decision repeats. The first decision after reset starts a run of length 1.
- R5: A sampled decision that differs from the previous one clears coarse at that edge and restarts the run at length 1.
- R6: Suppose coarse is 1 before an edge and the sampled decision equals the previous one. Then the count moves by two in the direction of the decision.
- R7: The count never exceeds N and never goes below 0. A step that would pass either end stops exactly at that end.
- R8: at_limit is 1 exactly when the count is 0 or N.
- R9: In a closed loop with a behavioural load model, a step in load from 8 to 13 switches drives the count to at least 13 within 8 control cycles, and the loop passes through coarse mode on the way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_low | input | 1 | Comparator decision: 1 means the output is below the reference |
| sw_en | output | N | Thermometer-coded enables for the PMOS switch array |
| coarse | output | 1 | Mode flag: 1 is coarse (double step), 0 is fine |
| at_limit | output | 1 | Count is pinned at 0 or at N |

## Verification
The decision sampled at one rising edge shows up in sw_en, coarse and at_limit right after that same edge. All three outputs come from registers updated at that edge, so each result is due one cycle after its input. The bench drives cmp_low half a cycle before the edge and compares all outputs at the following falling edge against a model updated from the requirements for that edge. It walks every 8-decision pattern from reset, runs long one-sided streams into both clamps, and closes the loop through a load model whose next decision depends on the count just observed.

// File: rtl/dldo_pkg.sv
package dldo_pkg;
   typedef enum logic {MODE_FINE = 1'b0, MODE_COARSE = 1'b1} mode_e;
   localparam int STEP_FINE   = 1;
   localparam int STEP_COARSE = 2;
endpackage

// File: rtl/dldo_run_det.sv
module dldo_run_det #(
   parameter int K = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dec,
   output logic match,
   output logic coarse
);
   import dldo_pkg::*;
   localparam int RW = $clog2(K + 1);

   if (K < 2) begin : g_bad_k
      $error("dldo_run_det: K must be at least 2");
   end

   logic          last_q;
   logic [RW-1:0] run_q;
   mode_e         mode;

   assign match  = (run_q != '0) && (dec == last_q);
   assign mode   = (run_q >= RW'(K)) ? MODE_COARSE : MODE_FINE;
   assign coarse = (mode == MODE_COARSE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q <= 1'b0;
         run_q  <= '0;
      end else begin
         last_q <= dec;
         if (match) begin
            run_q <= (run_q >= RW'(K)) ? RW'(K) : run_q + RW'(1);
         end else begin
            run_q <= RW'(1);
         end
      end
   end

   // R5
   mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !match |=> !coarse);

   // R4
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (coarse && match) |=> coarse);
endmodule

// File: rtl/dldo_therm_reg.sv
module dldo_therm_reg #(
   parameter int N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         up,
   input  logic         dbl,
   output logic [N-1:0] sw_en,
   output logic         at_limit
);
   import dldo_pkg::*;
   localparam int CW = $clog2(N + 1);

   if (N < 2 || (N % 2) != 0) begin : g_bad_n
      $error("dldo_therm_reg: N must be even and at least 2");
   end

   logic [CW-1:0] cnt_q, cnt_d;
   logic [CW:0]   stp, sum;

   assign stp = dbl ? (CW+1)'(STEP_COARSE) : (CW+1)'(STEP_FINE);
   assign sum = {1'b0, cnt_q} + stp;

   always_comb begin
      if (up) begin
         cnt_d = (sum > (CW+1)'(N)) ? CW'(N) : sum[CW-1:0];
      end else begin
         cnt_d = ({1'b0, cnt_q} < stp) ? '0 : cnt_q - stp[CW-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= CW'(N / 2);
      else        cnt_q <= cnt_d;
   end

   for (genvar i = 0; i < N; i++) begin : g_therm
      assign sw_en[i] = (cnt_q > CW'(i));
   end

   assign at_limit = (cnt_q == '0) || (cnt_q == CW'(N));

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(N));

   // R2
   therm_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((sw_en + N'(1)) & sw_en) == '0);
endmodule

// File: rtl/dldo_ctrl.sv
module dldo_ctrl #(
   parameter int N = 16,
   parameter int K = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cmp_low,
   output logic [N-1:0] sw_en,
   output logic         coarse,
   output logic         at_limit
);
   logic match;

   dldo_run_det #(.K(K)) u_run (
      .clk   (clk),
      .rst_n (rst_n),
      .dec   (cmp_low),
      .match (match),
      .coarse(coarse)
   );

   dldo_therm_reg #(.N(N)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .up      (cmp_low),
      .dbl     (coarse && match),
      .sw_en   (sw_en),
      .at_limit(at_limit)
   );

   // R3
   fine_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(coarse) |->
         ($countones(sw_en) <= $past($countones(sw_en)) + 1) &&
         ($countones(sw_en) + 1 >= $past($countones(sw_en))));

   // R6
   coarse_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(sw_en) <= $past($countones(sw_en)) + 2) &&
      ($countones(sw_en) + 2 >= $past($countones(sw_en))));

   // R3
   direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmp_low) |-> ($countones(sw_en) >= $past($countones(sw_en))));

   // R1
   reset_mode_chk: assert property (@(posedge clk)
      !rst_n |=> !coarse);
endmodule

// File: tb/tb_dldo_ctrl.sv
module tb_dldo_ctrl;
   localparam int N = 16;
   localparam int K = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmp_low = 1'b0;
   logic [N-1:0] sw_en;
   logic         coarse;
   logic         at_limit;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   bit done = 0;

   int m_cnt, m_run, m_last, m_coarse, m_have;

   always #2.5 clk = ~clk;

   dldo_ctrl #(.N(N), .K(K)) dut (
      .clk(clk), .rst_n(rst_n), .cmp_low(cmp_low),
      .sw_en(sw_en), .coarse(coarse), .at_limit(at_limit)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         errors++; checks++;
         $display("FAIL R9 watchdog actual=%0d expected<150000", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [N-1:0] therm(int c);
      logic [N-1:0] v = '0;
      for (int i = 0; i < N; i++) if (i < c) v[i] = 1'b1;
      return v;
   endfunction

   task automatic compare_all();
      chk("R2 sw_en", int'(sw_en), int'(therm(m_cnt)));
      chk("R4/R5 coarse", int'(coarse), m_coarse);
      chk("R8 at_limit", int'(at_limit), (m_cnt == 0 || m_cnt == N) ? 1 : 0);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_cnt = N / 2; m_run = 0; m_last = 0; m_coarse = 0; m_have = 0;
      chk("R1 reset count", $countones(sw_en), N / 2);
      chk("R1 reset coarse", int'(coarse), 0);
   endtask

   task automatic tick(bit d);
      int match, stp, prev;
      cmp_low = d;
      @(posedge clk);
      match = (m_have != 0 && int'(d) == m_last) ? 1 : 0;
      stp = (m_coarse != 0 && match != 0) ? 2 : 1;
      prev = m_cnt;
      if (d) m_cnt = (m_cnt + stp > N) ? N : m_cnt + stp;
      else   m_cnt = (m_cnt - stp < 0) ? 0 : m_cnt - stp;
      m_run = match ? ((m_run + 1 > K) ? K : m_run + 1) : 1;
      m_coarse = (m_run >= K) ? 1 : 0;
      m_last = int'(d);
      m_have = 1;
      @(negedge clk);
      if (stp == 2) chk("R6 coarse step", $countones(sw_en), m_cnt);
      else          chk("R3 fine step", $countones(sw_en), m_cnt);
      if (prev == N || prev == 0) chk("R7 clamp", $countones(sw_en), m_cnt);
      compare_all();
   endtask

   initial begin
      int v, load, reached, saw_coarse;
      @(negedge clk);
      do_reset();
      chk("R1 reset pattern", int'(sw_en), 16'h00FF);

      // near-exhaustive: every 8-decision pattern from reset (R3 R4 R5 R6)
      for (int p = 0; p < 256; p++) begin
         do_reset();
         for (int b = 0; b < 8; b++) tick(p[b]);
      end

      // R7 upper clamp and R8
      do_reset();
      for (int i = 0; i < 20; i++) tick(1'b1);
      chk("R7 top clamp", $countones(sw_en), N);
      chk("R8 top limit", int'(at_limit), 1);
      // R5 reversal from the top
      tick(1'b0);
      chk("R5 clear on change", int'(coarse), 0);
      chk("R3 one step down", $countones(sw_en), N - 1);
      // R7 lower clamp
      for (int i = 0; i < 20; i++) tick(1'b0);
      chk("R7 bottom clamp", $countones(sw_en), 0);
      chk("R8 bottom limit", int'(at_limit), 1);
      tick(1'b1);
      chk("R3 leave bottom", $countones(sw_en), 1);
      chk("R8 off limit", int'(at_limit), 0);

      // R1 reset in mid-operation
      for (int i = 0; i < 5; i++) tick(1'b1);
      do_reset();

      // R9 closed loop with load step
      v = 0; load = 13; reached = 0; saw_coarse = 0;
      for (int i = 0; i < 8; i++) begin
         v = v + $countones(sw_en) - load;
         tick(v < 0);
         if (coarse) saw_coarse = 1;
         if (reached == 0 && $countones(sw_en) >= load) reached = i + 1;
      end
      chk("R9 recovered", (reached > 0) ? 1 : 0, 1);
      chk("R9 coarse used", saw_coarse, 1);
      for (int i = 0; i < 40; i++) begin
         v = v + $countones(sw_en) - load;
         tick(v < 0);
      end
      chk("R9 settled band", ($countones(sw_en) >= load - 3 &&
                              $countones(sw_en) <= load + 3) ? 1 : 0, 1);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule